// File: doc/BRIEF.md
# Second-Level Cache Coherence Message Dispatcher

This block sits at the data-array stage of a second-level cache and takes at most one coherence message per cycle. It decodes each message from three things: its class (a coherence request or a coherence reply), its request type (writeback, invalidate or other) and the write policy of the first-level cache. From that decode it does one of five things. It sends a writeback up to the first-level cache. It sends an invalidate up to the first-level cache together with a writeback down toward memory. It returns the message descriptor to the free pool. It flags the message as illegal and drops it. Or it hands the message to the downstream queue as a copyback.

Replies that carry a writeback merged with an invalidate have to reach the first-level cache from the reply path, or inclusion between the two cache levels is lost. The writeback half of such a pair must never block the pipe. When the downstream queue cannot take it in the cycle it arrives, it is parked in a small slot buffer, and the slot index goes onto a deferred-send list. The slot is released only in the cycle the deferred list actually hands the writeback downstream. The deferred list has priority on the downstream port over anything new.

The upward port to the first-level cache has no ready signal, because the first-level cache always sinks these messages. The downstream port uses a valid/ready handshake. The first-level write policy is a static configuration input.

Top module: `l2_coh_dispatch`

## Requirements
- R1: A message with class 0 (coherence request), type 0 (writeback) and `cfg_l1_wt`=0 is accepted in the same cycle. It appears on the upward port with `up_kind`=0 (writeback) and its own tag.
- R2: A class-0 message of any other type, or any class-0 message while `cfg_l1_wt`=1, is accepted in the same cycle and sends nothing on any port. `err_flag` is high from the next cycle on and stays high until reset.
- R3: A message with class 1 (coherence reply) and `in_absorb`=1 is accepted in the same cycle. Its tag appears on `free_valid`/`free_tag`, and it drives neither `up_valid` nor the downstream port.
- R4: A class-1, type-0, non-absorbed message while `cfg_l1_wt`=1 is a merged pair. When accepted, it puts an invalidate (`up_kind`=1) with its tag on the upward port in that cycle. Its writeback (`dn_kind`=0) leaves on the downstream port either in that same cycle or later through the deferred list.
- R5: A class-1, type-0, non-absorbed message while `cfg_l1_wt`=0 is accepted in the same cycle and sends nothing. `err_flag` is set from the next cycle on.
- R6: Any other non-absorbed class-1 message (type 1 or 2) goes downstream as a copyback (`dn_kind`=1) with its tag. It is accepted only in a cycle where `dn_ready` is high and the deferred list is empty.
- R7: A merged pair whose writeback cannot leave directly takes a buffer slot and is accepted. It is refused (`in_ready`=0) only when the deferred list is non-empty and all WB_DEPTH (default 4) slots are held.
- R8: While the deferred list is non-empty, the downstream port shows its oldest writeback. Deferred writebacks leave in acceptance order, and a slot stays held until its writeback is sent.
- R9: After reset, `up_valid`, `dn_valid`, `free_valid` and `err_flag` are low, and the deferred list is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_l1_wt | input | 1 | First-level write policy: 0 write-back, 1 write-through |
| in_valid | input | 1 | Message present |
| in_ready | output | 1 | Message accepted this cycle |
| in_cls | input | 1 | 0 coherence request, 1 coherence reply |
| in_typ | input | 2 | 0 writeback, 1 invalidate, 2 or 3 other |
| in_absorb | input | 1 | Reply is consumed at this level |
| in_tag | input | TAG_W | Message address tag |
| up_valid | output | 1 | Message to the first-level cache |
| up_kind | output | 1 | 0 writeback, 1 invalidate |
| up_tag | output | TAG_W | Tag of upward message |
| dn_valid | output | 1 | Downstream message valid |
| dn_ready | input | 1 | Downstream queue can take a message |
| dn_kind | output | 1 | 0 writeback, 1 copyback |
| dn_tag | output | TAG_W | Tag of downstream message |
| free_valid | output | 1 | Descriptor returned to the pool |
| free_tag | output | TAG_W | Tag of returned descriptor |
| err_flag | output | 1 | Sticky illegal-message flag |

## Verification
The assertions assume that `cfg_l1_wt` changes only while no message is offered. They also assume every input is driven to a known value at each clock edge. They place no hold requirement on the input side, so an offered message may be withdrawn while `in_ready` is low. They rely on the deferred list never being pushed while it is full, and that in turn relies on the slot buffer and the list having the same depth. The stimulus changes the policy only between phases, with `in_valid` held low. Random messages are mixed with directed runs that hold `dn_ready` low long enough to fill every slot and reach the refusal case.

// File: rtl/l2cd_pkg.sv
package l2cd_pkg;
   // Message class carried on in_cls
   typedef enum logic {
      CLS_REQ   = 1'b0,
      CLS_REPLY = 1'b1
   } cls_e;

   // Request type carried on in_typ (3 is treated as other)
   typedef enum logic [1:0] {
      TY_WB    = 2'd0,
      TY_INV   = 2'd1,
      TY_OTHER = 2'd2,
      TY_RSVD  = 2'd3
   } typ_e;

   // Routing decision for one message
   typedef enum logic [2:0] {
      ACT_UP_WB   = 3'd0,
      ACT_PAIR    = 3'd1,
      ACT_ABSORB  = 3'd2,
      ACT_ILLEGAL = 3'd3,
      ACT_COPY    = 3'd4
   } act_e;
endpackage

// File: rtl/l2cd_decode.sv
module l2cd_decode
   import l2cd_pkg::*;
(
   input  logic       cls,
   input  logic [1:0] typ,
   input  logic       absorb,
   input  logic       l1_wt,
   output act_e       act
);
   logic is_wb;
   assign is_wb = (typ == TY_WB);

   always_comb begin
      if (cls == CLS_REQ) begin
         act = (is_wb && !l1_wt) ? ACT_UP_WB : ACT_ILLEGAL;
      end else if (absorb) begin
         act = ACT_ABSORB;
      end else if (is_wb) begin
         act = l1_wt ? ACT_PAIR : ACT_ILLEGAL;
      end else begin
         act = ACT_COPY;
      end
   end
endmodule

// File: rtl/l2cd_wbbuf.sv
module l2cd_wbbuf #(
   parameter int DEPTH = 4,
   parameter int TAG_W = 16,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             alloc,
   input  logic [TAG_W-1:0] alloc_tag,
   input  logic             rel,
   input  logic [IDX_W-1:0] rel_idx,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             any_free,
   output logic [IDX_W-1:0] free_idx,
   output logic [TAG_W-1:0] rd_tag
);
   logic [DEPTH-1:0]            occ;
   logic [DEPTH-1:0]            set_vec;
   logic [DEPTH-1:0]            clr_vec;
   logic [DEPTH-1:0][TAG_W-1:0] tags;

   // lowest-numbered empty slot wins
   always_comb begin
      any_free = 1'b0;
      free_idx = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (!occ[i]) begin
            any_free = 1'b1;
            free_idx = IDX_W'(i);
         end
      end
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      assign set_vec[g] = alloc && (free_idx == IDX_W'(g));
      assign clr_vec[g] = rel && (rel_idx == IDX_W'(g));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) occ <= '0;
      else        occ <= (occ & ~clr_vec) | set_vec;
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < DEPTH; i++) begin
         if (set_vec[i]) tags[i] <= alloc_tag;
      end
   end

   assign rd_tag = tags[rd_idx];

   a_r7_alloc_has_room: assert property (@(posedge clk) disable iff (!rst_n)
      alloc |-> any_free);
   a_r7_one_slot_taken: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(set_vec));
   a_r8_release_held: assert property (@(posedge clk) disable iff (!rst_n)
      rel |-> occ[rel_idx]);
endmodule

// File: rtl/l2cd_defer_fifo.sv
module l2cd_defer_fifo #(
   parameter int DEPTH = 4,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int PTR_W = IDX_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [IDX_W-1:0] push_idx,
   input  logic             pop,
   output logic             nonempty,
   output logic [IDX_W-1:0] head_idx
);
   logic [IDX_W-1:0] q [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, fill;

   assign fill     = wr_ptr - rd_ptr;
   assign nonempty = (fill != '0);
   assign head_idx = q[rd_ptr[IDX_W-1:0]];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + 1'b1;
         if (pop)  rd_ptr <= rd_ptr + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (push) q[wr_ptr[IDX_W-1:0]] <= push_idx;
   end

   a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop) |-> (fill < PTR_W'(DEPTH)));
   a_r8_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> nonempty);
endmodule

// File: rtl/l2_coh_dispatch.sv
module l2_coh_dispatch
   import l2cd_pkg::*;
#(
   parameter int TAG_W    = 16,
   parameter int WB_DEPTH = 4,
   localparam int IDX_W   = $clog2(WB_DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_l1_wt,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic             in_cls,
   input  logic [1:0]       in_typ,
   input  logic             in_absorb,
   input  logic [TAG_W-1:0] in_tag,
   output logic             up_valid,
   output logic             up_kind,
   output logic [TAG_W-1:0] up_tag,
   output logic             dn_valid,
   input  logic             dn_ready,
   output logic             dn_kind,
   output logic [TAG_W-1:0] dn_tag,
   output logic             free_valid,
   output logic [TAG_W-1:0] free_tag,
   output logic             err_flag
);
   initial begin
      if (WB_DEPTH < 2 || (WB_DEPTH & (WB_DEPTH - 1)) != 0)
         $error("WB_DEPTH must be a power of two of at least 2");
      if (TAG_W < 1)
         $error("TAG_W must be positive");
   end

   act_e             act;
   logic             dq_ne, any_free, direct_ok, alloc, pop;
   logic [IDX_W-1:0] head_idx, free_idx;
   logic [TAG_W-1:0] head_tag;

   l2cd_decode u_dec (
      .cls(in_cls), .typ(in_typ), .absorb(in_absorb), .l1_wt(cfg_l1_wt), .act(act)
   );

   l2cd_wbbuf #(.DEPTH(WB_DEPTH), .TAG_W(TAG_W)) u_buf (
      .clk(clk), .rst_n(rst_n), .alloc(alloc), .alloc_tag(in_tag),
      .rel(pop), .rel_idx(head_idx), .rd_idx(head_idx),
      .any_free(any_free), .free_idx(free_idx), .rd_tag(head_tag)
   );

   l2cd_defer_fifo #(.DEPTH(WB_DEPTH)) u_defer (
      .clk(clk), .rst_n(rst_n), .push(alloc), .push_idx(free_idx),
      .pop(pop), .nonempty(dq_ne), .head_idx(head_idx)
   );

   // the downstream port belongs to the deferred list whenever it holds anything
   assign direct_ok = !dq_ne && dn_ready;
   assign pop       = dq_ne && dn_ready;

   always_comb begin
      unique case (act)
         ACT_COPY: in_ready = direct_ok;
         ACT_PAIR: in_ready = direct_ok || any_free;
         default:  in_ready = 1'b1;
      endcase
   end

   assign alloc = in_valid && (act == ACT_PAIR) && !direct_ok && any_free;

   assign up_valid = in_valid && in_ready && ((act == ACT_UP_WB) || (act == ACT_PAIR));
   assign up_kind  = (act == ACT_PAIR);
   assign up_tag   = in_tag;

   assign dn_valid = dq_ne || (in_valid && ((act == ACT_COPY) || (act == ACT_PAIR)));
   assign dn_kind  = dq_ne ? 1'b0 : (act == ACT_COPY);
   assign dn_tag   = dq_ne ? head_tag : in_tag;

   assign free_valid = in_valid && (act == ACT_ABSORB);
   assign free_tag   = in_tag;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               err_flag <= 1'b0;
      else if (in_valid && act == ACT_ILLEGAL)  err_flag <= 1'b1;
   end

   a_r1_upwb_taken: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_cls == CLS_REQ && in_typ == TY_WB && !cfg_l1_wt)
      |-> (in_ready && up_valid && !up_kind));
   a_r2_req_illegal_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_cls == CLS_REQ && (in_typ != TY_WB || cfg_l1_wt)) |=> err_flag);
   a_r2_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag |=> err_flag);
   a_r3_absorb_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_cls == CLS_REPLY && in_absorb)
      |-> (in_ready && free_valid && !up_valid));
   a_r4_pair_invalidates: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_cls == CLS_REPLY && !in_absorb && in_typ == TY_WB && cfg_l1_wt)
      |-> (up_valid && up_kind && dn_valid));
   a_r5_reply_illegal_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_cls == CLS_REPLY && !in_absorb && in_typ == TY_WB && !cfg_l1_wt) |=> err_flag);
   a_r6_copy_needs_port: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && act == ACT_COPY) |-> (dn_ready && dn_valid && dn_kind));
   a_r8_head_held: assert property (@(posedge clk) disable iff (!rst_n)
      (dq_ne && !dn_ready) |=> (dn_valid && !dn_kind && $stable(dn_tag)));
endmodule

// File: tb/l2_coh_dispatch_tb.sv
module l2_coh_dispatch_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int TAG_W      = 16;
   localparam int DEPTH      = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cfg_l1_wt = 1'b0;
   logic             in_valid = 1'b0, in_cls = 1'b0, in_absorb = 1'b0, dn_ready = 1'b0;
   logic [1:0]       in_typ = 2'd0;
   logic [TAG_W-1:0] in_tag = '0;
   logic             in_ready, up_valid, up_kind, dn_valid, dn_kind, free_valid, err_flag;
   logic [TAG_W-1:0] up_tag, dn_tag, free_tag;

   int n_tests = 0;
   int n_fail  = 0;
   logic [TAG_W-1:0] mq[$];
   bit err_m = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   l2_coh_dispatch #(.TAG_W(TAG_W), .WB_DEPTH(DEPTH)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_l1_wt(cfg_l1_wt),
      .in_valid(in_valid), .in_ready(in_ready), .in_cls(in_cls), .in_typ(in_typ),
      .in_absorb(in_absorb), .in_tag(in_tag),
      .up_valid(up_valid), .up_kind(up_kind), .up_tag(up_tag),
      .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_kind(dn_kind), .dn_tag(dn_tag),
      .free_valid(free_valid), .free_tag(free_tag), .err_flag(err_flag)
   );

   // 0 up writeback, 1 pair, 2 absorb, 3 illegal request, 4 illegal reply, 5 copyback
   function automatic int route(bit c, logic [1:0] t, bit a, bit wt);
      if (!c) return (t == 2'd0 && !wt) ? 0 : 3;
      if (a) return 2;
      if (t == 2'd0) return wt ? 1 : 4;
      return 5;
   endfunction

   function automatic string req_of(int r);
      case (r)
         0: return "R1";
         1: return "R4";
         2: return "R3";
         3: return "R2";
         4: return "R5";
         default: return "R6";
      endcase
   endfunction

   task automatic chk(string req, string what, longint act, longint exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic step(bit v, bit c, logic [1:0] t, bit a, logic [TAG_W-1:0] tg, bit dr);
      int  r;
      bit  dq_ne, direct, e_rdy, e_up, e_dn, alloc;
      string rq;
      @(negedge clk);
      in_valid = v; in_cls = c; in_typ = t; in_absorb = a; in_tag = tg; dn_ready = dr;
      #1;
      r      = route(c, t, a, cfg_l1_wt);
      rq     = req_of(r);
      dq_ne  = (mq.size() > 0);
      direct = !dq_ne && dr;
      e_rdy  = (r == 5) ? direct : (r == 1) ? (direct || mq.size() < DEPTH) : 1'b1;
      if (v) chk((r == 1 && !e_rdy) ? "R7" : rq, "in_ready", in_ready, e_rdy);
      e_up = v && e_rdy && (r == 0 || r == 1);
      chk(rq, "up_valid", up_valid, e_up);
      if (e_up) begin
         chk(rq, "up_kind", up_kind, (r == 1));
         chk(rq, "up_tag", up_tag, tg);
      end
      e_dn = dq_ne || (v && (r == 1 || r == 5));
      chk(dq_ne ? "R8" : rq, "dn_valid", dn_valid, e_dn);
      if (e_dn) begin
         chk(dq_ne ? "R8" : rq, "dn_kind", dn_kind, dq_ne ? 0 : (r == 5));
         chk(dq_ne ? "R8" : rq, "dn_tag", dn_tag, dq_ne ? mq[0] : tg);
      end
      chk("R3", "free_valid", free_valid, v && r == 2);
      if (v && r == 2) chk("R3", "free_tag", free_tag, tg);
      chk(r == 4 ? "R5" : "R2", "err_flag", err_flag, err_m);
      // model commit for the coming edge
      alloc = v && r == 1 && !direct && (mq.size() < DEPTH);
      if (dq_ne && dr) void'(mq.pop_front());
      if (alloc) mq.push_back(tg);
      if (v && (r == 3 || r == 4)) err_m = 1'b1;
   endtask

   task automatic do_reset();
      @(negedge clk);
      in_valid = 1'b0; dn_ready = 1'b0; rst_n = 1'b0;
      #1;
      chk("R9", "up_valid", up_valid, 0);
      chk("R9", "dn_valid", dn_valid, 0);
      chk("R9", "free_valid", free_valid, 0);
      chk("R9", "err_flag", err_flag, 0);
      mq.delete();
      err_m = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      do_reset();
      // R1 / R3 directed with write-back first level
      cfg_l1_wt = 1'b0;
      step(1, 0, 2'd0, 0, 16'h1111, 1);
      step(1, 1, 2'd0, 1, 16'h2222, 0);
      step(1, 1, 2'd2, 0, 16'h3333, 0);   // R6 refused
      step(1, 1, 2'd1, 0, 16'h3334, 1);   // R6 accepted
      step(0, 0, 2'd0, 0, 16'h0, 1);
      // R5 then sticky R2
      step(1, 1, 2'd0, 0, 16'h4444, 1);
      step(0, 0, 2'd0, 0, 16'h0, 1);
      step(0, 0, 2'd0, 0, 16'h0, 1);
      do_reset();
      // R2 directed: invalidate request
      step(1, 0, 2'd1, 0, 16'h5555, 1);
      step(0, 0, 2'd0, 0, 16'h0, 1);
      do_reset();
      // R4/R7/R8: fill every slot with the port blocked, then drain
      cfg_l1_wt = 1'b1;
      step(0, 0, 2'd0, 0, 16'h0, 0);
      for (int i = 0; i < DEPTH + 2; i++) step(1, 1, 2'd0, 0, TAG_W'(16'hA0 + i), 0);
      step(1, 1, 2'd2, 0, 16'hBEEF, 1);   // copyback waits behind the list
      for (int i = 0; i < DEPTH + 2; i++) step(0, 0, 2'd0, 0, 16'h0, 1);
      step(1, 0, 2'd0, 0, 16'h6666, 1);   // R2 request writeback under write-through
      do_reset();
      // random phases, policy changed only while idle
      for (int ph = 0; ph < 6; ph++) begin
         step(0, 0, 2'd0, 0, 16'h0, 1);
         cfg_l1_wt = ph[0];
         for (int k = 0; k < 400; k++) begin
            step(($urandom % 4) != 0, $urandom % 2, 2'($urandom % 4),
                 ($urandom % 4) == 0, TAG_W'($urandom), ($urandom % 3) != 0);
         end
         if (ph == 3) do_reset();
      end
      step(0, 0, 2'd0, 0, 16'h0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule